// File: doc/BRIEF.md
# BCD Timekeeper Register File

This block keeps the calendar and clock registers of a real-time clock: control, seconds, minutes, hours, day-of-week with a century flag, date, month and year, all held and presented as packed BCD bytes. A one-second `tick` pulse moves the time forward. The year, month and date roll over with month lengths that include leap Februaries. A stop bit kept beside the seconds freezes the count. A host reaches the registers through a byte-wide request/response port. Each write is checked field by field. A value that fails the check leaves that field alone. Reads return the fields with fixed masking rules applied.

The request channel uses valid/ready. A request moves when `req_valid` and `req_ready` are both high on a rising clock edge. A write takes effect at that edge. A read loads a one-entry response slot, and `rsp_valid` rises in the following cycle. The response stays valid, with `rsp_data` unchanged, until `rsp_ready` is high at an edge. While a response waits and `rsp_ready` is low, `req_ready` is low, so no further request is taken. A source may hold `req_valid` for as long as it needs to. Nothing is lost or repeated.

The flags byte belongs to alarm and watchdog logic outside this block. It enters on `flags_in`, and this block only passes it through on reads.

Top module: `bcd_tod_regs`

## Requirements
- R1: After reset the registers read as follows: seconds 0x00 with the stop bit clear, minutes 0x00, hours 0x00, day register 0x01 (weekday 1, century 0), date 0x01, month 0x01, year 0x00, control 0x90.
- R2: `req_ready` equals (not `rsp_valid`) or `rsp_ready`. A read accepted at an edge gives `rsp_valid` high after that edge, carrying the register value from before the edge. `rsp_valid` and `rsp_data` hold until an edge where `rsp_ready` is high.
- R3: On a tick with the stop bit clear, seconds step in BCD. At 59, seconds wrap to 00 and carry into minutes, which also wrap at 59. Minutes carry into hours, which wrap from 23 to 00.
- R4: When the hours wrap, the date steps on. After the last day of the month the date becomes 01 and the month steps on. Month lengths are 30 for months 04, 06, 09 and 11, 31 for the other months, and 28 or 29 for 02 (29 when the year value is divisible by 4). After month 12 comes 01, and the year steps on, wrapping from 99 to 00.
- R5: The weekday (day register bits 2:0) steps on whenever the date steps on, going from 7 to 1.
- R6: The stop bit is bit 7 of the seconds location. While it is set, ticks change nothing. Clearing it lets counting resume from the frozen value. A seconds read returns the stop bit in bit 7 and the BCD seconds in bits 6:0.
- R7: A seconds or minutes write takes the value from data bits 6:0. The value is kept only if both nibbles are decimal digits and it is at most 0x59. A seconds write always stores data bit 7 as the stop bit.
- R8: An hours write takes data bits 5:0. The value is kept only if both nibbles are digits and it is at most 0x23.
- R9: A date write takes data bits 4:0 and must have a digit low nibble and be nonzero. A month write takes data bits 4:0 and must be 0x01 to 0x12. A year write takes all 8 bits and must be two digits. A rejected value leaves the field unchanged. Dates above 19 are reached only by counting.
- R10: A day-register write sets the weekday from data bits 2:0 and the century flag from data bit 6. A read returns the century flag in bit 6 and the weekday in bits 2:0, with the other bits zero.
- R11: A control write stores the data with bits 7 and 5 cleared and with bits 7 and 4 set. A control read returns the stored byte.
- R12: Address map: 0 flags (reads `flags_in`, writes ignored), 1 spare (reads 0x00, writes ignored), 2 control, 3 seconds, 4 minutes, 5 hours, 6 day/century, 7 date, 8 month, 9 year. Any other address reads 0xFF and ignores writes.
- R13: When a write and an unfrozen tick arrive in the same cycle, a kept write value replaces the ticked value of its own field. All other fields, and a field whose write value is rejected, take their ticked values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-second advance pulse, one cycle wide |
| flags_in | input | 8 | Flags byte presented at address 0 |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 8 | Read response data |

## Verification
The bench builds the block with ADDR_W = 4. That gives 16 addresses, so the six unmapped locations (10 to 15) can be hit by random and directed accesses as well as the ten mapped ones. A reference model in the bench keeps time in binary and converts to BCD only when it predicts a read. Random stimulus mixes reads, writes (valid, invalid and out-of-range BCD), ticks and stalled responses. Directed runs step through the ends of February in leap and non-leap years, the end of April, the year wrap at 99, stop and resume, and the case where a write and a tick land in the same cycle.

// File: rtl/bcd_tod_pkg.sv
package bcd_tod_pkg;

  // Register locations inside the window
  localparam int ADR_FLAGS = 0;
  localparam int ADR_SPARE = 1;
  localparam int ADR_CTRL  = 2;
  localparam int ADR_SEC   = 3;
  localparam int ADR_MIN   = 4;
  localparam int ADR_HOUR  = 5;
  localparam int ADR_DAY   = 6;
  localparam int ADR_DATE  = 7;
  localparam int ADR_MONTH = 8;
  localparam int ADR_YEAR  = 9;

  localparam logic [7:0] CTRL_CLR = 8'hA0;
  localparam logic [7:0] CTRL_SET = 8'h90;
  localparam logic [7:0] NO_LOC   = 8'hFF;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] date;
    logic [7:0] month;
    logic [7:0] year;
    logic [2:0] wday;
  } tod_t;

  typedef struct packed {
    logic sec;
    logic stop;
    logic min;
    logic hour;
    logic day;
    logic date;
    logic month;
    logic year;
    logic ctrl;
  } tod_we_t;

  localparam tod_t TOD_RESET = '{sec: 8'h00, min: 8'h00, hour: 8'h00,
                                 date: 8'h01, month: 8'h01, year: 8'h00,
                                 wday: 3'd1};

  function automatic logic bcd_ok(input logic [7:0] v);
    return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9);
  endfunction

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  function automatic logic [7:0] bcd_bin(input logic [7:0] v);
    return ({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]};
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
    logic [7:0] yb;
    logic [7:0] len;
    yb = bcd_bin(yr);
    case (mon)
      8'h02:                      len = (yb[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'h04, 8'h06, 8'h09, 8'h11: len = 8'd30;
      default:                    len = 8'd31;
    endcase
    return len;
  endfunction

endpackage

// File: rtl/bcd_tod_ctr.sv
// One BCD counter stage with a wrap limit and a carry to the next stage.
module bcd_tod_ctr
  import bcd_tod_pkg::*;
#(
  parameter logic [7:0] LIMIT = 8'h59
) (
  input  logic [7:0] val_i,
  input  logic       inc_i,
  output logic [7:0] val_o,
  output logic       carry_o
);
  logic at_lim;

  assign at_lim  = (val_i >= LIMIT);
  assign carry_o = inc_i && at_lim;
  assign val_o   = !inc_i ? val_i : (at_lim ? 8'h00 : bcd_inc(val_i));
endmodule

// File: rtl/bcd_tod_advance.sv
// Combinational one-second step of the whole calendar.
module bcd_tod_advance
  import bcd_tod_pkg::*;
(
  input  tod_t cur_i,
  output tod_t nxt_o
);
  localparam int N_HMS = 3;

  logic [7:0]   hms_in  [N_HMS];
  logic [7:0]   hms_out [N_HMS];
  logic [N_HMS:0] carry;

  assign hms_in[0] = cur_i.sec;
  assign hms_in[1] = cur_i.min;
  assign hms_in[2] = cur_i.hour;
  assign carry[0]  = 1'b1;

  generate
    for (genvar g = 0; g < N_HMS; g++) begin : g_hms
      localparam logic [7:0] LIM = (g == N_HMS - 1) ? 8'h23 : 8'h59;
      bcd_tod_ctr #(.LIMIT(LIM)) u_ctr (
        .val_i  (hms_in[g]),
        .inc_i  (carry[g]),
        .val_o  (hms_out[g]),
        .carry_o(carry[g+1])
      );
    end
  endgenerate

  logic       day_end;
  logic       last_day;
  logic [7:0] mlen;
  logic [7:0] date_b;

  always_comb begin
    nxt_o      = cur_i;
    nxt_o.sec  = hms_out[0];
    nxt_o.min  = hms_out[1];
    nxt_o.hour = hms_out[2];
    day_end    = carry[N_HMS];
    mlen       = month_len(cur_i.month, cur_i.year);
    date_b     = bcd_bin(cur_i.date);
    last_day   = (date_b >= mlen);
    if (day_end) begin
      nxt_o.wday = (cur_i.wday >= 3'd7) ? 3'd1 : cur_i.wday + 3'd1;
      if (last_day) begin
        nxt_o.date = 8'h01;
        if (cur_i.month >= 8'h12) begin
          nxt_o.month = 8'h01;
          nxt_o.year  = (cur_i.year >= 8'h99) ? 8'h00 : bcd_inc(cur_i.year);
        end else begin
          nxt_o.month = bcd_inc(cur_i.month);
        end
      end else begin
        nxt_o.date = bcd_inc(cur_i.date);
      end
    end
  end
endmodule

// File: rtl/bcd_tod_wdec.sv
// Write decode: picks the field, masks the data and validates the value.
module bcd_tod_wdec
  import bcd_tod_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output tod_we_t           we_o,
  output tod_t              val_o,
  output logic              stop_o,
  output logic              cent_o,
  output logic [7:0]        ctrl_o
);
  logic [7:0] s7, h6, d5;

  always_comb begin
    s7     = {1'b0, data_i[6:0]};
    h6     = {2'b00, data_i[5:0]};
    d5     = {3'b000, data_i[4:0]};
    val_o  = '{sec: s7, min: s7, hour: h6, date: d5, month: d5,
               year: data_i, wday: data_i[2:0]};
    stop_o = data_i[7];
    cent_o = data_i[6];
    ctrl_o = (data_i & ~CTRL_CLR) | CTRL_SET;
    we_o   = '0;
    if (wr_i) begin
      case (addr_i)
        ADDR_W'(ADR_CTRL):  we_o.ctrl  = 1'b1;
        ADDR_W'(ADR_SEC): begin
          we_o.stop = 1'b1;
          we_o.sec  = bcd_ok(s7) && (s7 <= 8'h59);
        end
        ADDR_W'(ADR_MIN):   we_o.min   = bcd_ok(s7) && (s7 <= 8'h59);
        ADDR_W'(ADR_HOUR):  we_o.hour  = bcd_ok(h6) && (h6 <= 8'h23);
        ADDR_W'(ADR_DAY):   we_o.day   = 1'b1;
        ADDR_W'(ADR_DATE):  we_o.date  = bcd_ok(d5) && (d5 != 8'h00);
        ADDR_W'(ADR_MONTH): we_o.month = bcd_ok(d5) && (d5 >= 8'h01) && (d5 <= 8'h12);
        ADDR_W'(ADR_YEAR):  we_o.year  = bcd_ok(data_i);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bcd_tod_rmux.sv
// Read selection with the per-location masking rules.
module bcd_tod_rmux
  import bcd_tod_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  tod_t              tod_i,
  input  logic              stop_i,
  input  logic              cent_i,
  input  logic [7:0]        ctrl_i,
  input  logic [7:0]        flags_i,
  output logic [7:0]        data_o
);
  always_comb begin
    case (addr_i)
      ADDR_W'(ADR_FLAGS): data_o = flags_i;
      ADDR_W'(ADR_SPARE): data_o = 8'h00;
      ADDR_W'(ADR_CTRL):  data_o = ctrl_i;
      ADDR_W'(ADR_SEC):   data_o = {stop_i, tod_i.sec[6:0]};
      ADDR_W'(ADR_MIN):   data_o = tod_i.min;
      ADDR_W'(ADR_HOUR):  data_o = tod_i.hour;
      ADDR_W'(ADR_DAY):   data_o = {1'b0, cent_i, 3'b000, tod_i.wday};
      ADDR_W'(ADR_DATE):  data_o = tod_i.date;
      ADDR_W'(ADR_MONTH): data_o = tod_i.month;
      ADDR_W'(ADR_YEAR):  data_o = tod_i.year;
      default:            data_o = NO_LOC;
    endcase
  end
endmodule

// File: rtl/bcd_tod_regs.sv
module bcd_tod_regs
  import bcd_tod_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [7:0]        flags_in,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [7:0]        rsp_data
);
  tod_t       time_q, time_adv, time_nxt, wval;
  tod_we_t    we;
  logic       stop_q, cent_q;
  logic [7:0] ctrl_q;
  logic       wr_acc, rd_acc, adv_en;
  logic       wstop, wcent;
  logic [7:0] wctrl, rdata;

  assign req_ready = !rsp_valid || rsp_ready;
  assign wr_acc    = req_valid && req_ready && req_write;
  assign rd_acc    = req_valid && req_ready && !req_write;
  assign adv_en    = tick && !stop_q;

  bcd_tod_advance u_adv (
    .cur_i(time_q),
    .nxt_o(time_adv)
  );

  bcd_tod_wdec #(.ADDR_W(ADDR_W)) u_wdec (
    .wr_i  (wr_acc),
    .addr_i(req_addr),
    .data_i(req_wdata),
    .we_o  (we),
    .val_o (wval),
    .stop_o(wstop),
    .cent_o(wcent),
    .ctrl_o(wctrl)
  );

  bcd_tod_rmux #(.ADDR_W(ADDR_W)) u_rmux (
    .addr_i (req_addr),
    .tod_i  (time_q),
    .stop_i (stop_q),
    .cent_i (cent_q),
    .ctrl_i (ctrl_q),
    .flags_i(flags_in),
    .data_o (rdata)
  );

  // Written field wins over its ticked value; other fields keep the tick.
  always_comb begin
    time_nxt = adv_en ? time_adv : time_q;
    if (we.sec)   time_nxt.sec   = wval.sec;
    if (we.min)   time_nxt.min   = wval.min;
    if (we.hour)  time_nxt.hour  = wval.hour;
    if (we.day)   time_nxt.wday  = wval.wday;
    if (we.date)  time_nxt.date  = wval.date;
    if (we.month) time_nxt.month = wval.month;
    if (we.year)  time_nxt.year  = wval.year;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q <= TOD_RESET;
      stop_q <= 1'b0;
      cent_q <= 1'b0;
      ctrl_q <= CTRL_SET;
    end else begin
      time_q <= time_nxt;
      if (we.stop) stop_q <= wstop;
      if (we.day)  cent_q <= wcent;
      if (we.ctrl) ctrl_q <= wctrl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= 8'h00;
    end else if (rd_acc) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rdata;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bcd_tod_regs_chk.sv
module bcd_tod_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       req_write,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [7:0] rsp_data,
  input logic       stop_q,
  input logic       wr_any,
  input logic [7:0] sec_q,
  input logic [7:0] hour_q,
  input logic [7:0] date_q,
  input logic [7:0] month_q,
  input logic [7:0] ctrl_q
);
  p_rsp_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  p_rsp_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(req_valid && req_ready && !req_write));

  p_sec_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_q <= 8'h59) && (sec_q[3:0] <= 4'd9));

  p_stop_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q && !wr_any |=> $stable(sec_q));

  p_hour_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hour_q <= 8'h23) && (hour_q[3:0] <= 4'd9));

  p_month_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (month_q >= 8'h01) && (month_q <= 8'h12) && (date_q != 8'h00));

  p_ctrl_form_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[7] && ctrl_q[4] && !ctrl_q[5]);
endmodule

bind bcd_tod_regs bcd_tod_regs_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_write(req_write),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_data (rsp_data),
  .stop_q   (stop_q),
  .wr_any   (wr_acc),
  .sec_q    (time_q.sec),
  .hour_q   (time_q.hour),
  .date_q   (time_q.date),
  .month_q  (time_q.month),
  .ctrl_q   (ctrl_q)
);

// File: tb/sim_bcd_tod_regs.sv
`timescale 1ns/1ps
module sim_bcd_tod_regs;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic [7:0] flags_in;
  logic       req_valid, req_ready, req_write;
  logic [3:0] req_addr;
  logic [7:0] req_wdata;
  logic       rsp_valid, rsp_ready;
  logic [7:0] rsp_data;

  always #4 clk = ~clk;

  bcd_tod_regs #(.ADDR_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .flags_in(flags_in),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  int nvec = 0;
  int nbad = 0;

  // Reference model, time kept in binary
  int m_sec, m_min, m_hour, m_date, m_mon, m_year;
  logic [2:0] m_wday;
  bit m_stop, m_cent;
  logic [7:0] m_ctrl;
  bit m_rv;
  logic [7:0] m_rd;
  string m_tag;

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) * 16) + (v % 10));
  endfunction

  function automatic int from_bcd(input logic [7:0] v);
    if (v[3:0] > 4'd9 || v[7:4] > 4'd9) return -1;
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic int mdays(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] m_read(input logic [3:0] a);
    logic [7:0] t;
    case (a)
      4'd0: t = flags_in;
      4'd1: t = 8'h00;
      4'd2: t = m_ctrl;
      4'd3: begin t = to_bcd(m_sec); t[7] = m_stop; end
      4'd4: t = to_bcd(m_min);
      4'd5: t = to_bcd(m_hour);
      4'd6: t = {1'b0, m_cent, 3'b000, m_wday};
      4'd7: t = to_bcd(m_date);
      4'd8: t = to_bcd(m_mon);
      4'd9: t = to_bcd(m_year);
      default: t = 8'hFF;
    endcase
    return t;
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    case (a)
      4'd2: return "R11";
      4'd3: return "R3 R6 R7 R13";
      4'd4: return "R3 R7";
      4'd5: return "R3 R8";
      4'd6: return "R5 R10";
      4'd7, 4'd8, 4'd9: return "R4 R9";
      default: return "R12";
    endcase
  endfunction

  task automatic m_tick();
    m_sec++;
    if (m_sec >= 60) begin
      m_sec = 0; m_min++;
      if (m_min >= 60) begin
        m_min = 0; m_hour++;
        if (m_hour >= 24) begin
          m_hour = 0;
          m_wday = (m_wday >= 3'd7) ? 3'd1 : m_wday + 3'd1;
          if (m_date >= mdays(m_mon, m_year)) begin
            m_date = 1;
            if (m_mon >= 12) begin
              m_mon = 1;
              m_year = (m_year >= 99) ? 0 : m_year + 1;
            end else m_mon++;
          end else m_date++;
        end
      end
    end
  endtask

  task automatic m_write(input logic [3:0] a, input logic [7:0] d);
    int x;
    case (a)
      4'd2: m_ctrl = (d & 8'h5F) | 8'h90;
      4'd3: begin
        x = from_bcd({1'b0, d[6:0]});
        if (x >= 0 && x <= 59) m_sec = x;
        m_stop = d[7];
      end
      4'd4: begin x = from_bcd({1'b0, d[6:0]}); if (x >= 0 && x <= 59) m_min = x; end
      4'd5: begin x = from_bcd({2'b0, d[5:0]}); if (x >= 0 && x <= 23) m_hour = x; end
      4'd6: begin m_wday = d[2:0]; m_cent = d[6]; end
      4'd7: begin x = from_bcd({3'b0, d[4:0]}); if (x >= 1) m_date = x; end
      4'd8: begin x = from_bcd({3'b0, d[4:0]}); if (x >= 1 && x <= 12) m_mon = x; end
      4'd9: begin x = from_bcd(d); if (x >= 0) m_year = x; end
      default: ;
    endcase
  endtask

  task automatic chk8(input logic [7:0] act, input logic [7:0] exp, input string tag, input string what);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit v, input bit w, input logic [3:0] a, input logic [7:0] d,
                      input bit t, input bit rr, input string tag);
    bit rdy, acc, nrv;
    logic [7:0] nrd;
    string ntag;
    @(negedge clk);
    req_valid = v; req_write = w; req_addr = a; req_wdata = d;
    tick = t; rsp_ready = rr; flags_in = 8'($urandom);
    #1;
    rdy = !m_rv || rr;
    chk8({7'd0, req_ready}, {7'd0, rdy}, "R2", "req_ready");
    acc = v && rdy;
    nrv = m_rv; nrd = m_rd; ntag = m_tag;
    if (acc && !w) begin
      nrv = 1'b1; nrd = m_read(a);
      ntag = (tag == "") ? tag_of(a) : tag;
    end else if (m_rv && rr) nrv = 1'b0;
    if (t && !m_stop) m_tick();
    if (acc && w) m_write(a, d);
    m_rv = nrv; m_rd = nrd; m_tag = ntag;
    @(posedge clk); #1;
    chk8({7'd0, rsp_valid}, {7'd0, m_rv}, "R2", "rsp_valid");
    if (m_rv) chk8(rsp_data, m_rd, m_tag, "rsp_data");
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    step(1, 1, a, d, 0, 1, "");
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 4'd0, 8'h00, 1, 1, "");
  endtask

  task automatic rd_expect(input logic [3:0] a, input logic [7:0] exp, input string tag);
    step(1, 0, a, 8'h00, 0, 1, tag);
    chk8(rsp_data, exp, tag, "directed read");
  endtask

  task automatic day_end(input int n);
    for (int i = 0; i < n; i++) begin
      wr(4'd5, 8'h23); wr(4'd4, 8'h59); wr(4'd3, 8'h59);
      tk(1);
    end
  endtask

  task automatic show_summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: actual running expected finished");
    show_summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0417));
    rst_n = 1'b0; tick = 0; flags_in = 8'h00; req_valid = 0; req_write = 0;
    req_addr = 0; req_wdata = 0; rsp_ready = 1;
    m_sec = 0; m_min = 0; m_hour = 0; m_date = 1; m_mon = 1; m_year = 0;
    m_wday = 3'd1; m_stop = 0; m_cent = 0; m_ctrl = 8'h90; m_rv = 0; m_rd = 8'h00; m_tag = "";
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state, R12 map
    rd_expect(4'd2, 8'h90, "R1");
    rd_expect(4'd3, 8'h00, "R1");
    rd_expect(4'd4, 8'h00, "R1");
    rd_expect(4'd5, 8'h00, "R1");
    rd_expect(4'd6, 8'h01, "R1");
    rd_expect(4'd7, 8'h01, "R1");
    rd_expect(4'd8, 8'h01, "R1");
    rd_expect(4'd9, 8'h00, "R1");
    rd_expect(4'd1, 8'h00, "R12");
    rd_expect(4'd12, 8'hFF, "R12");
    wr(4'd1, 8'h55); rd_expect(4'd1, 8'h00, "R12");
    wr(4'd13, 8'h12); rd_expect(4'd13, 8'hFF, "R12");

    // R11 control forcing
    wr(4'd2, 8'hFF); rd_expect(4'd2, 8'hDF, "R11");
    wr(4'd2, 8'h00); rd_expect(4'd2, 8'h90, "R11");

    // R7 R8 validation, R3 carries
    wr(4'd3, 8'h5A); rd_expect(4'd3, 8'h00, "R7");
    wr(4'd3, 8'h60); rd_expect(4'd3, 8'h00, "R7");
    wr(4'd4, 8'h7F); rd_expect(4'd4, 8'h00, "R7");
    wr(4'd5, 8'h24); rd_expect(4'd5, 8'h00, "R8");
    wr(4'd5, 8'hE3); rd_expect(4'd5, 8'h23, "R8");
    wr(4'd4, 8'h59); wr(4'd3, 8'h59); tk(1);
    rd_expect(4'd3, 8'h00, "R3");
    rd_expect(4'd4, 8'h00, "R3");
    rd_expect(4'd5, 8'h00, "R3");
    rd_expect(4'd7, 8'h02, "R4");
    rd_expect(4'd6, 8'h02, "R5");

    // R6 stop and resume
    wr(4'd3, 8'h90); tk(5); rd_expect(4'd3, 8'h90, "R6");
    wr(4'd3, 8'hE0); rd_expect(4'd3, 8'h90, "R6 R7");
    wr(4'd3, 8'h10); tk(1); rd_expect(4'd3, 8'h11, "R6");

    // R10 day/century and R5 weekday wrap
    wr(4'd6, 8'hC7); rd_expect(4'd6, 8'h47, "R10");
    day_end(1); rd_expect(4'd6, 8'h41, "R5 R10");

    // R9 field checks
    wr(4'd7, 8'h00); rd_expect(4'd7, 8'h03, "R9");
    wr(4'd7, 8'h1A); rd_expect(4'd7, 8'h03, "R9");
    wr(4'd7, 8'h21); rd_expect(4'd7, 8'h01, "R9");
    wr(4'd8, 8'h13); rd_expect(4'd8, 8'h01, "R9");
    wr(4'd8, 8'h00); rd_expect(4'd8, 8'h01, "R9");
    wr(4'd9, 8'hA0); rd_expect(4'd9, 8'h00, "R9");

    // R4 month ends
    wr(4'd9, 8'h23); wr(4'd8, 8'h02); wr(4'd7, 8'h19);
    day_end(9);  rd_expect(4'd7, 8'h28, "R4");
    day_end(1);  rd_expect(4'd7, 8'h01, "R4"); rd_expect(4'd8, 8'h03, "R4");
    wr(4'd9, 8'h24); wr(4'd8, 8'h02); wr(4'd7, 8'h19);
    day_end(10); rd_expect(4'd7, 8'h29, "R4");
    day_end(1);  rd_expect(4'd7, 8'h01, "R4"); rd_expect(4'd8, 8'h03, "R4");
    wr(4'd8, 8'h04); wr(4'd7, 8'h19);
    day_end(11); rd_expect(4'd7, 8'h30, "R4");
    day_end(1);  rd_expect(4'd8, 8'h05, "R4");
    wr(4'd9, 8'h99); wr(4'd8, 8'h12); wr(4'd7, 8'h19);
    day_end(12); rd_expect(4'd7, 8'h31, "R4");
    day_end(1);
    rd_expect(4'd7, 8'h01, "R4"); rd_expect(4'd8, 8'h01, "R4"); rd_expect(4'd9, 8'h00, "R4");

    // R13 write beats tick on its own field
    wr(4'd5, 8'h10); wr(4'd4, 8'h10); wr(4'd3, 8'h59);
    step(1, 1, 4'd3, 8'h30, 1, 1, "R13");
    rd_expect(4'd3, 8'h30, "R13"); rd_expect(4'd4, 8'h11, "R13");
    wr(4'd3, 8'h59);
    step(1, 1, 4'd3, 8'h75, 1, 1, "R13");
    rd_expect(4'd3, 8'h00, "R7 R13"); rd_expect(4'd4, 8'h12, "R13");

    // R2 back-pressure
    step(1, 0, 4'd4, 8'h00, 0, 0, "R2");
    step(1, 0, 4'd5, 8'h00, 0, 0, "R2");
    step(1, 0, 4'd5, 8'h00, 1, 0, "R2");
    step(0, 0, 4'd0, 8'h00, 0, 1, "R2");

    // Constrained random mix
    for (int i = 0; i < 20000; i++) begin
      logic [3:0] a;
      logic [7:0] d;
      bit w;
      a = 4'($urandom % 16);
      w = ($urandom % 2) == 0;
      if ($urandom % 2) d = to_bcd(int'($urandom % 100)) | {2'b0, 1'($urandom % 2), 5'b0};
      else d = 8'($urandom);
      if (a == 4'd3) d[7] = (($urandom % 10) == 0);
      step(($urandom % 10) < 7, w, a, d, ($urandom % 10) < 3, ($urandom % 10) < 7, "");
    end
    step(0, 0, 4'd0, 8'h00, 0, 1, "");

    show_summary();
    $finish;
  end
endmodule